// File: doc/BRIEF.md
# Double to Unsigned Word Converter

This block takes two IEEE-754 double-precision values packed side by side in a 128-bit operand. It turns each one into an unsigned 32-bit integer, always rounding toward zero. Any fraction is dropped whatever rounding mode the surrounding machine has selected. Values outside the unsigned word range saturate to the nearest limit. Each lane decides on its own whether its result is exact, truncated, saturated with an invalid-conversion report, or saturated with only an inexact report.

The result of each lane fills both 32-bit halves of that lane's 64-bit slot in the 128-bit output. The per-lane status bits are ORed across the lanes into three outputs: invalid conversion, signalling NaN and inexact. An operand is accepted on a cycle with `in_valid` high. Its result and flags appear together, registered, with `out_valid` on the next cycle. All outputs keep their values until the next accepted operand.

Top module: `dbl2uw_cvt`

## Requirements
- R1: A positive in-range input with a nonzero fraction (1.0 ≤ x < 2^32−1) gives the integer part and raises inexact only. For example, 3.75 gives 3.
- R2: An exact integer in range (0, 5, 2^32−1) gives that integer with no flag raised.
- R3: +infinity, or a finite input of 2^32 or above, gives 0xFFFF_FFFF with invalid set and inexact clear.
- R4: −infinity, or an input of −1.0 or below, gives 0 with invalid set and inexact clear.
- R5: An input strictly between −1.0 and 0 gives 0 with inexact only. −0.0 gives 0 with no flag.
- R6: An input strictly between 2^32−1 and 2^32 gives 0xFFFF_FFFF with inexact only.
- R7: A NaN (exponent all ones, fraction nonzero) gives 0 with invalid set. The NaN is quiet when fraction bit 51 is 1. When that bit is 0 it is signalling, and the signalling-NaN flag is also set.
- R8: A positive input below 1.0 gives 0. Inexact is set if the input is nonzero, including subnormals, and +0.0 raises no flag.
- R9: Lane 0 is read from input bits 63:0 and its word is written to output bits 31:0 and 63:32. Lane 1 is read from bits 127:64 and its word is written to bits 95:64 and 127:96.
- R10: Each flag output is the OR of that flag across both lanes.
- R11: After reset, out_valid, out_data and all flags are 0. out_valid is high exactly on the cycle after each cycle with in_valid high.
- R12: While in_valid is low, out_data and the flags hold their values, whatever is on in_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 128 | Two doubles, lane 1 in the upper half |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 128 | Converted words, each written twice in its lane slot |
| out_invalid | output | 1 | Invalid conversion in any lane |
| out_snan | output | 1 | Signalling NaN in any lane |
| out_inexact | output | 1 | Inexact result in any lane |

## Verification
The bench builds the block with its default parameters: two lanes, an 11-bit exponent, a 52-bit fraction and a 32-bit result. With these values the real saturation edges can be reached exactly, namely 2^32−1, 2^32−0.5 and 2^32. So can the smallest subnormal and the quiet/signalling split at fraction bit 51. Lanes are paired so that one lane raises a flag while the other stays clean, which exposes the OR merge and the word placement of each lane.

// File: rtl/dbl2uw_pkg.sv
package dbl2uw_pkg;
  typedef struct packed {
    logic inv;
    logic snan;
    logic inx;
  } cvt_flags_t;
endpackage

// File: rtl/dbl2uw_lane.sv
module dbl2uw_lane
  import dbl2uw_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32
) (
  input  logic [EXP_W+MAN_W:0] fp_in,
  output logic [INT_W-1:0]     word_out,
  output cvt_flags_t           flags_out
);
  localparam int FP_W  = 1 + EXP_W + MAN_W;
  localparam int SIG_W = MAN_W + 1;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_OVF  = EXP_W'(BIAS + INT_W);

  // Returns {inv, snan, inx, word}
  function automatic logic [INT_W+2:0] convert(input logic [FP_W-1:0] x);
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] fr;
    logic [SIG_W-1:0] sig, shifted, lost_mask;
    logic [INT_W-1:0] w;
    logic             inv, sn, inx;
    int               sh;
    sgn = x[FP_W-1];
    ex  = x[FP_W-2 -: EXP_W];
    fr  = x[MAN_W-1:0];
    w   = '0;
    inv = 1'b0;
    sn  = 1'b0;
    inx = 1'b0;
    sig = {1'b1, fr};
    shifted   = '0;
    lost_mask = '0;
    sh  = 0;
    if (ex == EXP_ONES) begin
      if (fr != '0) begin
        inv = 1'b1;
        sn  = ~fr[MAN_W-1];
      end else begin
        inv = 1'b1;
        w   = sgn ? '0 : '1;
      end
    end else if (sgn) begin
      if (ex == '0 && fr == '0) begin
        inx = 1'b0;
      end else if (ex >= EXP_ONE) begin
        inv = 1'b1;
      end else begin
        inx = 1'b1;
      end
    end else if (ex >= EXP_OVF) begin
      w   = '1;
      inv = 1'b1;
    end else if (ex < EXP_ONE) begin
      inx = (ex != '0) || (fr != '0);
    end else begin
      sh        = MAN_W - (int'(ex) - BIAS);
      shifted   = sig >> sh;
      lost_mask = ~({SIG_W{1'b1}} << sh);
      w         = shifted[INT_W-1:0];
      inx       = |(sig & lost_mask);
    end
    return {inv, sn, inx, w};
  endfunction

  logic [INT_W+2:0] res;
  assign res            = convert(fp_in);
  assign word_out       = res[INT_W-1:0];
  assign flags_out.inv  = res[INT_W+2];
  assign flags_out.snan = res[INT_W+1];
  assign flags_out.inx  = res[INT_W];
endmodule

// File: rtl/dbl2uw_flag_merge.sv
module dbl2uw_flag_merge
  import dbl2uw_pkg::*;
#(
  parameter int LANES = 2
) (
  input  cvt_flags_t [LANES-1:0] lane_flags,
  output cvt_flags_t             merged
);
  always_comb begin
    merged = '0;
    for (int i = 0; i < LANES; i++) begin
      merged.inv  = merged.inv  | lane_flags[i].inv;
      merged.snan = merged.snan | lane_flags[i].snan;
      merged.inx  = merged.inx  | lane_flags[i].inx;
    end
  end
endmodule

// File: rtl/dbl2uw_cvt.sv
module dbl2uw_cvt
  import dbl2uw_pkg::*;
#(
  parameter int LANES = 2,
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0] in_data,
  output logic                          out_valid,
  output logic [LANES*2*INT_W-1:0]      out_data,
  output logic                          out_invalid,
  output logic                          out_snan,
  output logic                          out_inexact
);
  localparam int FP_W   = 1 + EXP_W + MAN_W;
  localparam int SLOT_W = 2 * INT_W;

  logic [INT_W-1:0]        lane_word [LANES];
  cvt_flags_t [LANES-1:0]  lane_flags;
  logic [LANES-1:0]        lane_inv;
  logic [LANES-1:0]        lane_inx;
  logic [LANES*SLOT_W-1:0] packed_res;
  cvt_flags_t              merged;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dbl2uw_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_lane (
      .fp_in    (in_data[i*FP_W +: FP_W]),
      .word_out (lane_word[i]),
      .flags_out(lane_flags[i])
    );
    assign lane_inv[i] = lane_flags[i].inv;
    assign lane_inx[i] = lane_flags[i].inx;
    assign packed_res[i*SLOT_W +: SLOT_W] = {lane_word[i], lane_word[i]};
  end

  dbl2uw_flag_merge #(.LANES(LANES)) u_merge (
    .lane_flags(lane_flags),
    .merged    (merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
      out_snan    <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= packed_res;
        out_invalid <= merged.inv;
        out_snan    <= merged.snan;
        out_inexact <= merged.inx;
      end
    end
  end
endmodule

// File: rtl/dbl2uw_cvt_chk.sv
module dbl2uw_cvt_chk #(
  parameter int LANES = 2,
  parameter int INT_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic [LANES*2*INT_W-1:0] out_data,
  input logic                     out_invalid,
  input logic                     out_snan,
  input logic                     out_inexact,
  input logic [LANES-1:0]         lane_inv,
  input logic [LANES-1:0]         lane_inx
);
  p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_snan_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_snan |-> out_invalid);
  p_inv_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_invalid == $past(|lane_inv)) && (out_inexact == $past(|lane_inx)));
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data) && $stable(out_invalid)
                  && $stable(out_snan) && $stable(out_inexact));

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    p_word_dup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_data[i*2*INT_W +: INT_W] == out_data[i*2*INT_W+INT_W +: INT_W]);
    p_inv_inx_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !(lane_inv[i] && lane_inx[i]));
  end
endmodule

bind dbl2uw_cvt dbl2uw_cvt_chk #(.LANES(LANES), .INT_W(INT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_invalid(out_invalid),
  .out_snan   (out_snan),
  .out_inexact(out_inexact),
  .lane_inv   (lane_inv),
  .lane_inx   (lane_inx)
);

// File: tb/dbl2uw_cvt_bench.sv
module dbl2uw_cvt_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_invalid, out_snan, out_inexact;
  int total = 0;
  int bad = 0;

  localparam logic [63:0] P_INF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SUBN  = 64'h0000_0000_0000_0001;

  always #10 clk = ~clk;

  dbl2uw_cvt u_dbl2uw_cvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_invalid(out_invalid),
    .out_snan(out_snan), .out_inexact(out_inexact)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_pair(input string tag, input logic [63:0] a0, input logic [63:0] a1,
                          input logic [31:0] w0, input logic [31:0] w1,
                          input logic inv, input logic sn, input logic inx);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = {a1, a0};
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R11 valid"}, 128'(out_valid), 128'(1));
    chk({tag, " data R9"}, out_data, {w1, w1, w0, w0});
    chk({tag, " invalid"}, 128'(out_invalid), 128'(inv));
    chk({tag, " snan"}, 128'(out_snan), 128'(sn));
    chk({tag, " inexact"}, 128'(out_inexact), 128'(inx));
    @(negedge clk);
    chk({tag, " R11 valid low"}, 128'(out_valid), 128'(0));
  endtask

  task automatic t_reset;
    chk("R11 reset valid", 128'(out_valid), 128'(0));
    chk("R11 reset data", out_data, 128'(0));
    chk("R11 reset flags", 128'({out_invalid, out_snan, out_inexact}), 128'(0));
  endtask

  task automatic t_trunc;
    run_pair("R1 trunc", $realtobits(3.75), $realtobits(1000000.5), 32'd3, 32'd1000000, 0, 0, 1);
    run_pair("R1 trunc big", $realtobits(4294967294.25), $realtobits(7.0), 32'hFFFF_FFFE, 32'd7, 0, 0, 1);
  endtask

  task automatic t_exact;
    run_pair("R2 exact", $realtobits(0.0), $realtobits(4294967295.0), 32'd0, 32'hFFFF_FFFF, 0, 0, 0);
    run_pair("R2 five", $realtobits(5.0), $realtobits(1.0), 32'd5, 32'd1, 0, 0, 0);
  endtask

  task automatic t_high;
    run_pair("R3 high", $realtobits(4294967296.0), P_INF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0);
    run_pair("R3 huge", $realtobits(1.0e20), $realtobits(2.0), 32'hFFFF_FFFF, 32'd2, 1, 0, 0);
  endtask

  task automatic t_low;
    run_pair("R4 low", $realtobits(-1.0), N_INF, 32'd0, 32'd0, 1, 0, 0);
    run_pair("R4 neg big", $realtobits(6.0), $realtobits(-12345.5), 32'd6, 32'd0, 1, 0, 0);
  endtask

  task automatic t_neg_frac;
    run_pair("R5 neg frac", $realtobits(-0.5), $realtobits(9.0), 32'd0, 32'd9, 0, 0, 1);
    run_pair("R5 neg zero", N_ZERO, $realtobits(3.0), 32'd0, 32'd3, 0, 0, 0);
  endtask

  task automatic t_top_frac;
    run_pair("R6 top frac", $realtobits(4.0), $realtobits(4294967295.5), 32'd4, 32'hFFFF_FFFF, 0, 0, 1);
  endtask

  task automatic t_nan;
    run_pair("R7 qnan", QNAN, $realtobits(8.0), 32'd0, 32'd8, 1, 0, 0);
    run_pair("R7 snan", $realtobits(8.0), SNAN, 32'd8, 32'd0, 1, 1, 0);
  endtask

  task automatic t_small;
    run_pair("R8 subnormal", SUBN, $realtobits(0.0), 32'd0, 32'd0, 0, 0, 1);
    run_pair("R8 half", $realtobits(2.0), $realtobits(0.999), 32'd2, 32'd0, 0, 0, 1);
  endtask

  task automatic t_merge;
    run_pair("R10 merge", $realtobits(-2.0), $realtobits(1.5), 32'd0, 32'd1, 1, 0, 1);
  endtask

  task automatic t_hold;
    logic [127:0] keep;
    run_pair("R12 setup", $realtobits(11.0), $realtobits(22.5), 32'd11, 32'd22, 0, 0, 1);
    keep = out_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_data = {SNAN, P_INF};
    end
    @(negedge clk);
    chk("R12 hold data", out_data, keep);
    chk("R12 hold flags", 128'({out_invalid, out_snan, out_inexact}), 128'(3'b001));
    chk("R12 valid low", 128'(out_valid), 128'(0));
  endtask

  initial begin
    #(20 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trunc();
    t_exact();
    t_high();
    t_low();
    t_neg_frac();
    t_top_frac();
    t_nan();
    t_small();
    t_merge();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule